// File: doc/BRIEF.md
# Field Read-Delay Window Classifier

This block sits beside a field memory whose write and read sides each have a pointer-reset event and an advance enable. It watches those controls on one shared clock. At every read reset it decides whether the field about to be read is the one just written, the one before it, or neither reliably. It decides this from how many clock cycles have passed since the latest write reset. Two fixed windows, one for old data and one for new data, are separated by a band in which the result cannot be trusted. A second upper bound marks delays that are too long to trust.

While a field classified as new is being read, the block also keeps a running count of how far the read address trails the write address. It raises a flag on every read-advance cycle in which that distance has fallen to the minimum safe gap or below. After power-up, neither pointer is trusted until each port has seen a number of dummy advance cycles followed by its reset. Until then every classification is reported as invalid. All thresholds are parameters, so a scaled-down configuration can be exercised in a few hundred cycles.

Top module: `fdc_top`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `clsCode` is 00 and `clsStrobe`, `undetWarn`, `gapViol` and `ptrReady` are all low.
- R2: `ptrReady` rises only once each port has seen at least `INIT_CYC` advance cycles and then its own reset. A reset that arrives before that count is reached restarts the count. Once high, `ptrReady` stays high. A read reset taken while `ptrReady` is low yields code 00 (invalid) and no warning.
- R3: The delay of a read reset is d when it is sampled d clock cycles after the latest write reset. When `ptrReady` is high and d is at most `OLD_MAX`, the code is 01 (old field).
- R4: When `ptrReady` is high and d lies from `NEW_MIN` to `GAP_MAX` inclusive, the code is 10 (new field).
- R5: When `ptrReady` is high and d lies from `OLD_MAX`+1 to `NEW_MIN`-1, the code is 11 (undetermined). `undetWarn` pulses together with `clsStrobe` exactly when the code is 11.
- R6: When d exceeds `GAP_MAX` the code is 11. The delay count saturates at a value above `GAP_MAX` and never wraps, so a very long wait still gives 11.
- R7: `clsStrobe` is high for one cycle in the cycle after each read reset and at no other time. `clsCode` takes its new value in that same cycle and holds it until the next read reset.
- R8: A read reset loads the gap count with the number of write advances since the latest write reset. After that, each write advance adds one and each read advance subtracts one, and the count stays at or above zero. An enable sampled in the same cycle as its own port's reset is ignored.
- R9: `gapViol` is high in the cycle after a read-advance cycle in which `ptrReady` was high, the latest classification was 10, and the gap count was at most `GAP_MIN`. It is low in every other cycle.
- R10: When a write reset and a read reset are sampled in the same cycle, the read reset is classified against the previous write reset. The next read reset is then measured from the new write reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rstN | input | 1 | Asynchronous active-low reset |
| wrRst | input | 1 | Write pointer reset event |
| wrEn | input | 1 | Write advance enable |
| rdRst | input | 1 | Read pointer reset event |
| rdEn | input | 1 | Read advance enable |
| clsCode | output | 2 | Latched field class: 00 invalid, 01 old, 10 new, 11 undetermined |
| clsStrobe | output | 1 | One-cycle pulse marking a fresh classification |
| undetWarn | output | 1 | One-cycle pulse when the fresh class is undetermined |
| gapViol | output | 1 | Read came within the minimum gap of the write address |
| ptrReady | output | 1 | Both ports have completed pointer initialisation |

## Verification
The properties assume that all four control inputs are known after reset is released and that they change only away from the rising clock edge. They also assume that any pair of reset events, including simultaneous ones, is legal. The bench drives every input on the falling edge, so each control is stable across the sampling edge. It produces resets back to back and at the same time without breaking those assumptions. Delays are placed on both sides of every window edge. A read-dominated run drains the gap through the minimum, so the flag is exercised against a field classified as new and again after an old classification has disarmed it.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'b00,
    CLS_OLD   = 2'b01,
    CLS_NEW   = 2'b10,
    CLS_UNDET = 2'b11
  } clsCode_e;

  // strobes from control to datapath, valid for the current cycle
  typedef struct packed {
    logic wrClr;   // write reset sampled
    logic wrStep;  // write advance (not in a write reset cycle)
    logic rdLoad;  // read reset sampled
    logic rdStep;  // read advance (not in a read reset cycle)
    logic armed;   // both pointers initialised before this edge
  } fdcStb_t;

endpackage

// File: rtl/fdc_init_trk.sv
module fdc_init_trk #(
  parameter int INIT_CYC = 80
) (
  input  logic clk,
  input  logic rstN,
  input  logic portRst,
  input  logic portEn,
  output logic done
);
  localparam int IW = $clog2(INIT_CYC + 1);
  localparam logic [IW-1:0] INIT_V = IW'(INIT_CYC);

  logic [IW-1:0] dummyCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dummyCnt <= '0;
      done     <= 1'b0;
    end else if (!done) begin
      if (portRst) begin
        if (dummyCnt == INIT_V) done <= 1'b1;
        dummyCnt <= '0;
      end else if (portEn && dummyCnt != INIT_V) begin
        dummyCnt <= dummyCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fdc_ctrl.sv
module fdc_ctrl
  import fdc_pkg::*;
#(
  parameter int INIT_CYC = 80
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrRst,
  input  logic    wrEn,
  input  logic    rdRst,
  input  logic    rdEn,
  output fdcStb_t stb,
  output logic    ptrReady
);
  localparam int NPORT = 2;

  logic [NPORT-1:0] rstVec;
  logic [NPORT-1:0] enVec;
  logic [NPORT-1:0] doneVec;

  assign rstVec = {rdRst, wrRst};
  assign enVec  = {rdEn, wrEn};

  for (genvar p = 0; p < NPORT; p++) begin : g_trk
    fdc_init_trk #(.INIT_CYC(INIT_CYC)) trk_i (
      .clk    (clk),
      .rstN   (rstN),
      .portRst(rstVec[p]),
      .portEn (enVec[p]),
      .done   (doneVec[p])
    );
  end

  assign ptrReady = &doneVec;

  always_comb begin
    stb.wrClr  = wrRst;
    stb.wrStep = wrEn & ~wrRst;
    stb.rdLoad = rdRst;
    stb.rdStep = rdEn & ~rdRst;
    stb.armed  = ptrReady;
  end
endmodule

// File: rtl/fdc_datapath.sv
module fdc_datapath
  import fdc_pkg::*;
#(
  parameter int OLD_MAX = 70,
  parameter int NEW_MIN = 600,
  parameter int GAP_MAX = 262214,
  parameter int GAP_MIN = 600
) (
  input  logic       clk,
  input  logic       rstN,
  input  fdcStb_t    stb,
  output logic [1:0] clsCode,
  output logic       clsStrobe,
  output logic       undetWarn,
  output logic       gapViol
);
  localparam int CW = $clog2(GAP_MAX + 2);
  localparam logic [CW-1:0] CMAX   = '1;
  localparam logic [CW-1:0] OLD_V  = CW'(OLD_MAX);
  localparam logic [CW-1:0] NEW_V  = CW'(NEW_MIN);
  localparam logic [CW-1:0] GMAX_V = CW'(GAP_MAX);
  localparam logic [CW-1:0] GMIN_V = CW'(GAP_MIN);

  logic [CW-1:0] dlyCnt;
  logic [CW-1:0] wrPtr;
  logic [CW-1:0] gapCnt;
  logic          monOn;
  clsCode_e      nextCls;
  logic [CW-1:0] gapNext;

  // window decision on the delay seen at this edge
  always_comb begin
    if (!stb.armed)                              nextCls = CLS_NONE;
    else if (dlyCnt <= OLD_V)                    nextCls = CLS_OLD;
    else if (dlyCnt >= NEW_V && dlyCnt <= GMAX_V) nextCls = CLS_NEW;
    else                                         nextCls = CLS_UNDET;
  end

  always_comb begin
    gapNext = gapCnt;
    if (stb.rdLoad) begin
      gapNext = wrPtr;
    end else begin
      unique case ({stb.wrStep, stb.rdStep})
        2'b10:   if (gapCnt != CMAX) gapNext = gapCnt + 1'b1;
        2'b01:   if (gapCnt != '0)   gapNext = gapCnt - 1'b1;
        default: gapNext = gapCnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlyCnt <= CMAX;
      wrPtr  <= '0;
      gapCnt <= '0;
    end else begin
      if (stb.wrClr)            dlyCnt <= CW'(1);
      else if (dlyCnt != CMAX)  dlyCnt <= dlyCnt + 1'b1;

      if (stb.wrClr)                      wrPtr <= '0;
      else if (stb.wrStep && wrPtr != CMAX) wrPtr <= wrPtr + 1'b1;

      gapCnt <= gapNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clsCode   <= CLS_NONE;
      clsStrobe <= 1'b0;
      undetWarn <= 1'b0;
      gapViol   <= 1'b0;
      monOn     <= 1'b0;
    end else begin
      clsStrobe <= stb.rdLoad;
      undetWarn <= stb.rdLoad && (nextCls == CLS_UNDET);
      if (stb.rdLoad) begin
        clsCode <= nextCls;
        monOn   <= (nextCls == CLS_NEW);
      end
      gapViol <= stb.armed && monOn && stb.rdStep && (gapCnt <= GMIN_V);
    end
  end
endmodule

// File: rtl/fdc_top.sv
module fdc_top
  import fdc_pkg::*;
#(
  parameter int OLD_MAX  = 70,
  parameter int NEW_MIN  = 600,
  parameter int GAP_MAX  = 262214,
  parameter int GAP_MIN  = 600,
  parameter int INIT_CYC = 80
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrRst,
  input  logic       wrEn,
  input  logic       rdRst,
  input  logic       rdEn,
  output logic [1:0] clsCode,
  output logic       clsStrobe,
  output logic       undetWarn,
  output logic       gapViol,
  output logic       ptrReady
);
  fdcStb_t stb;

  fdc_ctrl #(.INIT_CYC(INIT_CYC)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrRst   (wrRst),
    .wrEn    (wrEn),
    .rdRst   (rdRst),
    .rdEn    (rdEn),
    .stb     (stb),
    .ptrReady(ptrReady)
  );

  fdc_datapath #(
    .OLD_MAX(OLD_MAX),
    .NEW_MIN(NEW_MIN),
    .GAP_MAX(GAP_MAX),
    .GAP_MIN(GAP_MIN)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .clsCode  (clsCode),
    .clsStrobe(clsStrobe),
    .undetWarn(undetWarn),
    .gapViol  (gapViol)
  );
endmodule

// File: rtl/fdc_checker.sv
module fdc_checker (
  input logic       clk,
  input logic       rstN,
  input logic       rdRst,
  input logic       rdEn,
  input logic [1:0] clsCode,
  input logic       clsStrobe,
  input logic       undetWarn,
  input logic       gapViol,
  input logic       ptrReady
);
  AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN) rdRst |=> clsStrobe); // R7
  AST_STROBE_ONLY: assert property (@(posedge clk) disable iff (!rstN) !rdRst |=> !clsStrobe); // R7
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rstN) !rdRst |=> $stable(clsCode)); // R7
  AST_WARN_UNDET: assert property (@(posedge clk) disable iff (!rstN) undetWarn |-> (clsStrobe && clsCode == 2'b11)); // R5
  AST_UNREADY_NONE: assert property (@(posedge clk) disable iff (!rstN) (rdRst && !ptrReady) |=> (clsCode == 2'b00)); // R2
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rstN) ptrReady |=> ptrReady); // R2
  AST_FLAG_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN) (!rdEn || rdRst) |=> !gapViol); // R9
  AST_FLAG_NEEDS_READY: assert property (@(posedge clk) disable iff (!rstN) !ptrReady |=> !gapViol); // R9
endmodule

bind fdc_top fdc_checker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .rdRst    (rdRst),
  .rdEn     (rdEn),
  .clsCode  (clsCode),
  .clsStrobe(clsStrobe),
  .undetWarn(undetWarn),
  .gapViol  (gapViol),
  .ptrReady (ptrReady)
);

// File: tb/fdc_top_tb_top.sv
module fdc_top_tb_top;
  localparam int OLD_MAX  = 7;
  localparam int NEW_MIN  = 20;
  localparam int GAP_MAX  = 40;
  localparam int GAP_MIN  = 12;
  localparam int INIT_CYC = 8;
  localparam int CMAX     = (1 << $clog2(GAP_MAX + 2)) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrRst = 1'b0, wrEn = 1'b0, rdRst = 1'b0, rdEn = 1'b0;
  logic [1:0] clsCode;
  logic clsStrobe, undetWarn, gapViol, ptrReady;

  always #5 clk = ~clk;

  fdc_top #(
    .OLD_MAX(OLD_MAX), .NEW_MIN(NEW_MIN), .GAP_MAX(GAP_MAX),
    .GAP_MIN(GAP_MIN), .INIT_CYC(INIT_CYC)
  ) dut_i (
    .clk(clk), .rstN(rstN), .wrRst(wrRst), .wrEn(wrEn), .rdRst(rdRst), .rdEn(rdEn),
    .clsCode(clsCode), .clsStrobe(clsStrobe), .undetWarn(undetWarn),
    .gapViol(gapViol), .ptrReady(ptrReady)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [1:0] expQ[$];

  // reference model state
  int mCnt = CMAX, mWrPtr = 0, mGap = 0, mLast = 0;
  int mDumW = 0, mDumR = 0;
  bit mWrInit = 0, mRdInit = 0, mMon = 0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: called at a falling edge, returns at the next falling edge
  task automatic step(bit wr, bit we, bit rr, bit re);
    bit ready;
    int code, expViol, g;
    wrRst = wr; wrEn = we; rdRst = rr; rdEn = re;
    ready = mWrInit && mRdInit;
    code = 0;
    if (rr) begin
      if (!ready) code = 0;
      else if (mCnt <= OLD_MAX) code = 1;
      else if (mCnt >= NEW_MIN && mCnt <= GAP_MAX) code = 2;
      else code = 3;
      expQ.push_back(code[1:0]);
    end
    expViol = (ready && mMon && re && !rr && mGap <= GAP_MIN) ? 1 : 0;
    if (rr) mGap = mWrPtr;
    else begin
      g = mGap + ((we && !wr) ? 1 : 0) - (re ? 1 : 0);
      if (g < 0) g = 0;
      if (g > CMAX) g = CMAX;
      mGap = g;
    end
    if (wr) mWrPtr = 0; else if (we && mWrPtr < CMAX) mWrPtr++;
    if (wr) mCnt = 1; else if (mCnt < CMAX) mCnt++;
    if (rr) begin mMon = ready && code == 2; mLast = code; end
    if (!mWrInit) begin
      if (wr) begin if (mDumW >= INIT_CYC) mWrInit = 1; mDumW = 0; end
      else if (we && mDumW < INIT_CYC) mDumW++;
    end
    if (!mRdInit) begin
      if (rr) begin if (mDumR >= INIT_CYC) mRdInit = 1; mDumR = 0; end
      else if (re && mDumR < INIT_CYC) mDumR++;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R9 gapViol", gapViol, expViol);
    chk("R2 ptrReady", ptrReady, (mWrInit && mRdInit) ? 1 : 0);
    chk("R7 strobe", clsStrobe, rr ? 1 : 0);
    chk("R7 code hold", clsCode, mLast);
  endtask

  // write reset, then a read reset d cycles later (R3 delay definition)
  task automatic delayRun(int d);
    step(1, 1, 0, 0);
    repeat (d - 1) step(0, 1, 0, 0);
    step(0, 0, 1, 0);
  endtask

  // monitor: pops expected classes as results appear
  always @(negedge clk) begin
    if (rstN && clsStrobe) begin
      if (expQ.size() == 0) begin
        total++; bad++;
        $display("FAIL R7 unexpected strobe actual=1 expected=0");
      end else begin
        logic [1:0] e;
        e = expQ.pop_front();
        chk("R3/R4/R6 class code", clsCode, e);
        chk("R5 undetWarn", undetWarn, (e == 2'b11) ? 1 : 0);
      end
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 clsCode", clsCode, 0);
    chk("R1 clsStrobe", clsStrobe, 0);
    chk("R1 undetWarn", undetWarn, 0);
    chk("R1 gapViol", gapViol, 0);
    chk("R1 ptrReady", ptrReady, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after release", {29'd0, clsStrobe, gapViol, ptrReady}, 0);

    // R2: read reset before initialisation gives invalid
    step(0, 0, 1, 0);
    // R2: early write reset restarts the dummy count
    repeat (3) step(0, 1, 0, 1);
    step(1, 0, 0, 0);
    repeat (INIT_CYC) step(0, 1, 0, 1);
    step(1, 0, 1, 0);   // both ports complete init; class still invalid

    // R3 old window and its edge
    delayRun(5);
    delayRun(OLD_MAX);
    // R5 undetermined band edges
    delayRun(OLD_MAX + 1);
    delayRun(NEW_MIN - 1);
    // R4 new window edges
    delayRun(NEW_MIN);
    delayRun(GAP_MAX);
    // R6 beyond upper bound, then saturated delay
    delayRun(GAP_MAX + 1);
    delayRun(100);

    // R10 simultaneous write and read reset
    delayRun(25);
    step(1, 0, 1, 0);
    step(0, 0, 1, 0);

    // R8/R9 gap drains through the minimum while reading a new field
    step(1, 1, 0, 0);
    repeat (24) step(0, 1, 0, 0);
    step(0, 0, 1, 0);
    repeat (3) step(0, 1, 0, 1);
    repeat (16) step(0, 0, 0, 1);
    // R9 old classification disarms the flag
    delayRun(3);
    repeat (5) step(0, 0, 0, 1);
    step(0, 0, 0, 0);

    total++;
    if (expQ.size() != 0) begin
      bad++;
      $display("FAIL R7 missing strobes actual=%0d expected=0", expQ.size());
    end
    finished = 1;
    summary();
    $finish;
  end
endmodule